// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block moves a 32-bit processor core into an exception handler and back out. Seven request lines (reset, undefined instruction, software trap, instruction-fetch abort, data abort, normal interrupt and fast interrupt) are arbitrated in a fixed order. The interrupt lines are gated by the mask bits of the current status word. A winning request produces one cycle of write strobes toward the register file. These strobes write the saved-status bank and the link register of the target mode, the new current status word and a program counter taken from a fixed vector table. A flush strobe discards the younger instructions that were already fetched.

Every request other than reset is taken only at an instruction boundary. That means a cycle in which the execute stage reports completion, or a cycle in which it holds nothing. The instruction that is executing therefore always finishes first. The same block also performs the handler return. In one update it copies the saved status word back into the current status and the link value into the program counter. A return attempted from an unprivileged mode, or from the privileged mode that shares the user register set, is refused and flagged.

Top module: `xcpt_seq`

## Requirements
- R1: During reset, and in any cycle with nothing to do, every write strobe, `flush_o` and `ret_err_o` is 0 and every data output is 0.
- R2: The new program counter on entry is `VEC_BASE` plus a cause offset: reset 0x00, undefined 0x04, software trap 0x08, fetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. Offset 0x14 is never produced.
- R3: Among simultaneous eligible requests the winner is chosen in this order: reset first, then data abort, fast interrupt, normal interrupt, fetch abort, and undefined instruction before software trap.
- R4: A normal interrupt is eligible only while status bit 7 (I) is 0. A fast interrupt is eligible only while status bit 6 (F) is 0.
- R5: On entry the saved-status bank of the target mode receives the current status word, and that mode's link register receives `ret_addr_i`. `bank_o` names the target mode.
- R6: The new status word keeps every other bit of the old one, with these changes: bit 5 (T) and bit 24 (J) are cleared, bit 7 (I) is set, and bits 4:0 hold the target mode. Reset and software trap select 10011, undefined selects 11011, both aborts select 10111, normal interrupt selects 10010 and fast interrupt selects 10001.
- R7: Bit 6 (F) of the new status is set on fast-interrupt and reset entry. Every other entry leaves it unchanged.
- R8: A non-reset request is taken only in a cycle with `ex_done_i` or `ex_idle_i` high. Reset is taken in any cycle. All strobes appear in the cycle after the request is sampled, and `flush_o` pulses with every entry and every return.
- R9: When `ret_req_i` and `ex_done_i` are high and no entry wins, one update writes `saved_i` to the status word and `link_i` to the program counter.
- R10: A return while bits 4:0 of the status are 10000 or 11111 writes nothing and pulses `ret_err_o` for one cycle.
- R11: In the cycle after any status update, no request other than reset and no return is accepted, so a changed mask bit takes effect before the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req_i | input | 1 | Reset exception request |
| und_req_i | input | 1 | Undefined-instruction request |
| swi_req_i | input | 1 | Software trap request |
| pabt_req_i | input | 1 | Instruction-fetch abort request |
| dabt_req_i | input | 1 | Data abort request |
| irq_req_i | input | 1 | Normal interrupt request |
| fiq_req_i | input | 1 | Fast interrupt request |
| ex_done_i | input | 1 | The execute stage completes an instruction this cycle |
| ex_idle_i | input | 1 | The execute stage holds no instruction |
| status_i | input | 32 | Current status word |
| ret_addr_i | input | XLEN | Return address for the link register |
| ret_req_i | input | 1 | Handler return request |
| saved_i | input | 32 | Saved status word of the current mode |
| link_i | input | XLEN | Link register of the current mode |
| saved_we_o | output | 1 | Write strobe for the saved-status bank |
| bank_o | output | 5 | Target mode selecting the saved-status and link bank |
| saved_wdata_o | output | 32 | Saved-status write data |
| link_we_o | output | 1 | Link register write strobe |
| link_wdata_o | output | XLEN | Link register write data |
| status_we_o | output | 1 | Current status write strobe |
| status_wdata_o | output | 32 | Current status write data |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_wdata_o | output | XLEN | Program counter write data |
| flush_o | output | 1 | Discard younger instructions in the pipeline |
| ret_err_o | output | 1 | Refused return |

## Verification
The bench raises several requests at once, in descending subsets, to walk the priority chain. A wrong order would vector to the wrong offset and select the wrong bank. Masked interrupts are offered with the other mask bit set to the opposite value. This exposes a design that swaps bits 6 and 7 or still takes the masked line. Requests are also raised with no instruction boundary, and a request is held across the cycle just after an update. Here a design that ignores completion or reads the stale status word would enter too early or twice. Returns are tried from an interrupt mode, from user mode and from system mode, and once together with a competing interrupt. Mode-checking mistakes and entry-versus-return precedence mistakes therefore show up as unexpected writes or a missing error pulse.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

   localparam int STW = 32;

   // Cause codes equal the vector slot index; slot 5 is never used.
   typedef enum logic [2:0] {
      CS_RST  = 3'd0,
      CS_UND  = 3'd1,
      CS_SWI  = 3'd2,
      CS_PABT = 3'd3,
      CS_DABT = 3'd4,
      CS_RSVD = 3'd5,
      CS_IRQ  = 3'd6,
      CS_FIQ  = 3'd7
   } cause_e;

   localparam int NCAUSE = 8;

   localparam logic [4:0] MD_USR = 5'b10000;
   localparam logic [4:0] MD_FIQ = 5'b10001;
   localparam logic [4:0] MD_IRQ = 5'b10010;
   localparam logic [4:0] MD_SVC = 5'b10011;
   localparam logic [4:0] MD_ABT = 5'b10111;
   localparam logic [4:0] MD_UND = 5'b11011;
   localparam logic [4:0] MD_SYS = 5'b11111;

   localparam int SB_J = 24;
   localparam int SB_I = 7;
   localparam int SB_F = 6;
   localparam int SB_T = 5;
   localparam int MODE_W = 5;

   function automatic logic [4:0] target_mode(input cause_e c);
      case (c)
         CS_RST, CS_SWI:   return MD_SVC;
         CS_UND:           return MD_UND;
         CS_PABT, CS_DABT: return MD_ABT;
         CS_IRQ:           return MD_IRQ;
         CS_FIQ:           return MD_FIQ;
         default:          return MD_UND;
      endcase
   endfunction

endpackage

// File: rtl/xcpt_arbiter.sv
module xcpt_arbiter
   import xcpt_pkg::*;
#(
   parameter int NC = NCAUSE
) (
   input  logic [NC-1:0] req_i,
   input  logic          irq_masked_i,
   input  logic          fiq_masked_i,
   input  logic          window_i,
   input  logic          busy_i,
   output logic          hit_o,
   output cause_e        cause_o
);

   localparam int NPRI = 7;
   localparam cause_e PRI [NPRI] = '{CS_RST, CS_DABT, CS_FIQ, CS_IRQ,
                                     CS_PABT, CS_UND, CS_SWI};

   if (NC != NCAUSE) begin : g_bad_nc
      $error("xcpt_arbiter: NC must equal the cause count");
   end

   logic [NC-1:0] elig;
   logic          open_slot;

   assign open_slot = window_i & ~busy_i;

   for (genvar g = 0; g < NC; g++) begin : g_elig
      if (g == int'(CS_RST)) begin : g_rst
         assign elig[g] = req_i[g];
      end else if (g == int'(CS_IRQ)) begin : g_irq
         assign elig[g] = req_i[g] & open_slot & ~irq_masked_i;
      end else if (g == int'(CS_FIQ)) begin : g_fiq
         assign elig[g] = req_i[g] & open_slot & ~fiq_masked_i;
      end else begin : g_sync
         assign elig[g] = req_i[g] & open_slot;
      end
   end

   // Walk from lowest to highest priority; the last match wins.
   always_comb begin
      hit_o   = 1'b0;
      cause_o = CS_RST;
      for (int k = NPRI - 1; k >= 0; k--) begin
         if (elig[PRI[k]]) begin
            hit_o   = 1'b1;
            cause_o = PRI[k];
         end
      end
   end

endmodule

// File: rtl/xcpt_status_gen.sv
module xcpt_status_gen
   import xcpt_pkg::*;
(
   input  logic [STW-1:0] cur_i,
   input  cause_e         cause_i,
   output logic [STW-1:0] new_o,
   output logic [4:0]     mode_o
);

   always_comb begin
      mode_o   = target_mode(cause_i);
      new_o    = cur_i;
      new_o[SB_T] = 1'b0;
      new_o[SB_J] = 1'b0;
      new_o[SB_I] = 1'b1;
      if (cause_i == CS_FIQ || cause_i == CS_RST) begin
         new_o[SB_F] = 1'b1;
      end
      new_o[MODE_W-1:0] = mode_o;
   end

endmodule

// File: rtl/xcpt_ret_gate.sv
module xcpt_ret_gate
   import xcpt_pkg::*;
(
   input  logic       ret_req_i,
   input  logic       ex_done_i,
   input  logic       busy_i,
   input  logic       entry_i,
   input  logic [4:0] mode_i,
   output logic       do_ret_o,
   output logic       err_o
);

   logic attempt;
   logic unpriv;

   assign attempt  = ret_req_i & ex_done_i & ~busy_i & ~entry_i;
   assign unpriv   = (mode_i == MD_USR) || (mode_i == MD_SYS);
   assign do_ret_o = attempt & ~unpriv;
   assign err_o    = attempt & unpriv;

endmodule

// File: rtl/xcpt_seq.sv
module xcpt_seq
   import xcpt_pkg::*;
#(
   parameter int               XLEN     = 32,
   parameter logic [XLEN-1:0]  VEC_BASE = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rst_req_i,
   input  logic            und_req_i,
   input  logic            swi_req_i,
   input  logic            pabt_req_i,
   input  logic            dabt_req_i,
   input  logic            irq_req_i,
   input  logic            fiq_req_i,
   input  logic            ex_done_i,
   input  logic            ex_idle_i,
   input  logic [31:0]     status_i,
   input  logic [XLEN-1:0] ret_addr_i,
   input  logic            ret_req_i,
   input  logic [31:0]     saved_i,
   input  logic [XLEN-1:0] link_i,
   output logic            saved_we_o,
   output logic [4:0]      bank_o,
   output logic [31:0]     saved_wdata_o,
   output logic            link_we_o,
   output logic [XLEN-1:0] link_wdata_o,
   output logic            status_we_o,
   output logic [31:0]     status_wdata_o,
   output logic            pc_we_o,
   output logic [XLEN-1:0] pc_wdata_o,
   output logic            flush_o,
   output logic            ret_err_o
);

   localparam int SLOT_SH = 2;

   if (XLEN < 8) begin : g_bad_xlen
      $error("xcpt_seq: XLEN must cover the vector table");
   end
   if (VEC_BASE[SLOT_SH-1:0] != '0) begin : g_bad_base
      $error("xcpt_seq: VEC_BASE must be word aligned");
   end

   logic [NCAUSE-1:0] req_vec;
   logic              hit;
   cause_e            win;
   logic              busy;
   logic              window;
   logic [31:0]       new_status;
   logic [4:0]        new_mode;
   logic              do_ret;
   logic              ret_err;
   logic [XLEN-1:0]   vec_addr;

   assign req_vec[CS_RST]  = rst_req_i;
   assign req_vec[CS_UND]  = und_req_i;
   assign req_vec[CS_SWI]  = swi_req_i;
   assign req_vec[CS_PABT] = pabt_req_i;
   assign req_vec[CS_DABT] = dabt_req_i;
   assign req_vec[CS_RSVD] = 1'b0;
   assign req_vec[CS_IRQ]  = irq_req_i;
   assign req_vec[CS_FIQ]  = fiq_req_i;

   assign window = ex_done_i | ex_idle_i;
   assign busy   = status_we_o;

   xcpt_arbiter #(.NC(NCAUSE)) u_arb (
      .req_i        (req_vec),
      .irq_masked_i (status_i[SB_I]),
      .fiq_masked_i (status_i[SB_F]),
      .window_i     (window),
      .busy_i       (busy),
      .hit_o        (hit),
      .cause_o      (win)
   );

   xcpt_status_gen u_stat (
      .cur_i   (status_i),
      .cause_i (win),
      .new_o   (new_status),
      .mode_o  (new_mode)
   );

   xcpt_ret_gate u_ret (
      .ret_req_i (ret_req_i),
      .ex_done_i (ex_done_i),
      .busy_i    (busy),
      .entry_i   (hit),
      .mode_i    (status_i[MODE_W-1:0]),
      .do_ret_o  (do_ret),
      .err_o     (ret_err)
   );

   assign vec_addr = VEC_BASE + XLEN'({win, {SLOT_SH{1'b0}}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saved_we_o     <= 1'b0;
         bank_o         <= '0;
         saved_wdata_o  <= '0;
         link_we_o      <= 1'b0;
         link_wdata_o   <= '0;
         status_we_o    <= 1'b0;
         status_wdata_o <= '0;
         pc_we_o        <= 1'b0;
         pc_wdata_o     <= '0;
         flush_o        <= 1'b0;
         ret_err_o      <= 1'b0;
      end else begin
         saved_we_o     <= 1'b0;
         bank_o         <= '0;
         saved_wdata_o  <= '0;
         link_we_o      <= 1'b0;
         link_wdata_o   <= '0;
         status_we_o    <= 1'b0;
         status_wdata_o <= '0;
         pc_we_o        <= 1'b0;
         pc_wdata_o     <= '0;
         flush_o        <= 1'b0;
         ret_err_o      <= ret_err;
         if (hit) begin
            saved_we_o     <= 1'b1;
            bank_o         <= new_mode;
            saved_wdata_o  <= status_i;
            link_we_o      <= 1'b1;
            link_wdata_o   <= ret_addr_i;
            status_we_o    <= 1'b1;
            status_wdata_o <= new_status;
            pc_we_o        <= 1'b1;
            pc_wdata_o     <= vec_addr;
            flush_o        <= 1'b1;
         end else if (do_ret) begin
            status_we_o    <= 1'b1;
            status_wdata_o <= saved_i;
            pc_we_o        <= 1'b1;
            pc_wdata_o     <= link_i;
            flush_o        <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/xcpt_seq_chk.sv
module xcpt_seq_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rst_req_i,
   input logic            ex_done_i,
   input logic            ex_idle_i,
   input logic [31:0]     status_i,
   input logic [XLEN-1:0] ret_addr_i,
   input logic [31:0]     saved_i,
   input logic [XLEN-1:0] link_i,
   input logic            saved_we_o,
   input logic [31:0]     saved_wdata_o,
   input logic [XLEN-1:0] link_wdata_o,
   input logic            status_we_o,
   input logic [31:0]     status_wdata_o,
   input logic            pc_we_o,
   input logic [XLEN-1:0] pc_wdata_o,
   input logic            ret_err_o
);

   p_vec_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      saved_we_o |-> pc_we_o && pc_wdata_o[1:0] == 2'b00 && pc_wdata_o[4:2] != 3'd5);

   p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (saved_we_o && status_wdata_o[4:0] == 5'b10010) |-> !$past(status_i[7]));

   p_fiq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (saved_we_o && status_wdata_o[4:0] == 5'b10001) |-> !$past(status_i[6]));

   p_saved_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      saved_we_o |-> saved_wdata_o == $past(status_i) && link_wdata_o == $past(ret_addr_i));

   p_arm_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      saved_we_o |-> !status_wdata_o[5] && !status_wdata_o[24] && status_wdata_o[7]);

   p_fbit_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (saved_we_o && (status_wdata_o[4:0] == 5'b10010 || status_wdata_o[4:0] == 5'b11011 ||
                      status_wdata_o[4:0] == 5'b10111))
      |-> status_wdata_o[6] == $past(status_i[6]));

   p_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (saved_we_o && !$past(rst_req_i)) |-> $past(ex_done_i || ex_idle_i));

   p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_we_o && !saved_we_o) |-> status_wdata_o == $past(saved_i) && pc_wdata_o == $past(link_i));

   p_ret_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ret_err_o |-> !status_we_o && !pc_we_o);

   p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      status_we_o |=> !status_we_o || $past(rst_req_i));

endmodule

bind xcpt_seq xcpt_seq_chk #(.XLEN(XLEN)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rst_req_i      (rst_req_i),
   .ex_done_i      (ex_done_i),
   .ex_idle_i      (ex_idle_i),
   .status_i       (status_i),
   .ret_addr_i     (ret_addr_i),
   .saved_i        (saved_i),
   .link_i         (link_i),
   .saved_we_o     (saved_we_o),
   .saved_wdata_o  (saved_wdata_o),
   .link_wdata_o   (link_wdata_o),
   .status_we_o    (status_we_o),
   .status_wdata_o (status_wdata_o),
   .pc_we_o        (pc_we_o),
   .pc_wdata_o     (pc_wdata_o),
   .ret_err_o      (ret_err_o)
);

// File: tb/xcpt_seq_tb_top.sv
module xcpt_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req, und_req, swi_req, pabt_req, dabt_req, irq_req, fiq_req;
   logic        ex_done, ex_idle, ret_req;
   logic [31:0] status, ret_addr, saved, link;

   logic        saved_we, link_we, status_we, pc_we, flush, ret_err;
   logic [4:0]  bank;
   logic [31:0] saved_wdata, link_wdata, status_wdata, pc_wdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   xcpt_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .rst_req_i(rst_req), .und_req_i(und_req), .swi_req_i(swi_req),
      .pabt_req_i(pabt_req), .dabt_req_i(dabt_req), .irq_req_i(irq_req),
      .fiq_req_i(fiq_req), .ex_done_i(ex_done), .ex_idle_i(ex_idle),
      .status_i(status), .ret_addr_i(ret_addr), .ret_req_i(ret_req),
      .saved_i(saved), .link_i(link),
      .saved_we_o(saved_we), .bank_o(bank), .saved_wdata_o(saved_wdata),
      .link_we_o(link_we), .link_wdata_o(link_wdata),
      .status_we_o(status_we), .status_wdata_o(status_wdata),
      .pc_we_o(pc_we), .pc_wdata_o(pc_wdata),
      .flush_o(flush), .ret_err_o(ret_err)
   );

   typedef struct {
      string       tag;
      logic        saved_we;
      logic [4:0]  bank;
      logic [31:0] saved;
      logic        link_we;
      logic [31:0] link;
      logic        st_we;
      logic [31:0] st;
      logic        pc_we;
      logic [31:0] pc;
      logic        flush;
      logic        err;
   } exp_t;

   exp_t q[$];
   logic model_busy = 1'b0;

   task automatic chk(input string tag, input string field, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h exp %h", tag, field, got, exp);
      end
   endtask

   task automatic idle_inputs();
      rst_req = 0; und_req = 0; swi_req = 0; pabt_req = 0; dabt_req = 0;
      irq_req = 0; fiq_req = 0; ex_done = 0; ex_idle = 1; ret_req = 0;
      status = 32'h0000_0013; ret_addr = 32'h0000_1000;
      saved = 32'h0; link = 32'h0;
   endtask

   // Independent reference of the requirements.
   function automatic exp_t model(input string tag);
      exp_t e;
      logic win, take;
      int   idx;
      logic [4:0] md;
      e = '{tag: tag, default: '0};
      win  = ex_done | ex_idle;
      take = 1'b1;
      idx  = 0;
      md   = 5'b10011;
      if (rst_req)                                   begin idx = 0; md = 5'b10011; end
      else if (!model_busy && win && dabt_req)       begin idx = 4; md = 5'b10111; end
      else if (!model_busy && win && fiq_req && !status[6]) begin idx = 7; md = 5'b10001; end
      else if (!model_busy && win && irq_req && !status[7]) begin idx = 6; md = 5'b10010; end
      else if (!model_busy && win && pabt_req)       begin idx = 3; md = 5'b10111; end
      else if (!model_busy && win && und_req)        begin idx = 1; md = 5'b11011; end
      else if (!model_busy && win && swi_req)        begin idx = 2; md = 5'b10011; end
      else take = 1'b0;
      if (take) begin
         e.saved_we = 1; e.bank = md; e.saved = status;
         e.link_we = 1; e.link = ret_addr;
         e.st_we = 1; e.st = status;
         e.st[5] = 0; e.st[24] = 0; e.st[7] = 1;
         if (idx == 7 || idx == 0) e.st[6] = 1;
         e.st[4:0] = md;
         e.pc_we = 1; e.pc = 32'(idx * 4);
         e.flush = 1;
      end else if (ret_req && ex_done && !model_busy) begin
         if (status[4:0] == 5'b10000 || status[4:0] == 5'b11111) begin
            e.err = 1;
         end else begin
            e.st_we = 1; e.st = saved; e.pc_we = 1; e.pc = link; e.flush = 1;
         end
      end
      return e;
   endfunction

   // Driver: inputs already set by caller; applied at falling edge.
   task automatic step(input string tag);
      exp_t e;
      e = model(tag);
      q.push_back(e);
      model_busy = e.st_we;
      @(negedge clk);
   endtask

   task automatic gap();
      idle_inputs();
      step("R1");
   endtask

   // Monitor: compares after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " R5"}, "saved_we", 32'(saved_we), 32'(e.saved_we));
            chk({e.tag, " R5"}, "bank", 32'(bank), 32'(e.bank));
            chk({e.tag, " R5"}, "saved_wdata", saved_wdata, e.saved);
            chk({e.tag, " R5"}, "link_we", 32'(link_we), 32'(e.link_we));
            chk({e.tag, " R5"}, "link_wdata", link_wdata, e.link);
            chk({e.tag, " R6 R7"}, "status_we", 32'(status_we), 32'(e.st_we));
            chk({e.tag, " R6 R7"}, "status_wdata", status_wdata, e.st);
            chk({e.tag, " R2"}, "pc_we", 32'(pc_we), 32'(e.pc_we));
            chk({e.tag, " R2"}, "pc_wdata", pc_wdata, e.pc);
            chk({e.tag, " R8"}, "flush", 32'(flush), 32'(e.flush));
            chk({e.tag, " R10"}, "ret_err", 32'(ret_err), 32'(e.err));
         end
      end
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog: got timeout exp completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs quiet under reset
      chk("R1", "reset strobes", 32'({saved_we, link_we, status_we, pc_we, flush, ret_err}), 32'h0);
      chk("R1", "reset pc", pc_wdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      gap(); gap();

      // R2 R6: each cause alone, status open, instruction boundary
      idle_inputs(); ex_done = 1; ex_idle = 0; und_req = 1;  step("R2 und");  gap();
      idle_inputs(); swi_req = 1;  step("R2 swi");  gap();
      idle_inputs(); pabt_req = 1; step("R2 pabt"); gap();
      idle_inputs(); dabt_req = 1; step("R2 dabt"); gap();
      idle_inputs(); irq_req = 1;  step("R2 irq");  gap();
      idle_inputs(); fiq_req = 1;  step("R2 fiq");  gap();
      idle_inputs(); rst_req = 1;  step("R2 rst");  gap();

      // R6 R7: flags kept, T and J cleared, F kept on irq entry
      idle_inputs(); status = 32'hF900_0070; irq_req = 1; ret_addr = 32'h0000_ABC4;
      step("R6 R7 irq keeps F"); gap();
      idle_inputs(); status = 32'h0100_0030; und_req = 1; step("R6 clears T J"); gap();
      idle_inputs(); status = 32'h0000_0090; fiq_req = 1; step("R7 fiq sets F"); gap();

      // R4: masking
      idle_inputs(); status = 32'h0000_0093; irq_req = 1; step("R4 irq masked"); gap();
      idle_inputs(); status = 32'h0000_0053; fiq_req = 1; step("R4 fiq masked"); gap();
      idle_inputs(); status = 32'h0000_0053; irq_req = 1; step("R4 irq open F set"); gap();

      // R3: priority chain
      idle_inputs(); rst_req = 1; dabt_req = 1; fiq_req = 1; irq_req = 1; pabt_req = 1; und_req = 1;
      step("R3 rst wins"); gap();
      idle_inputs(); dabt_req = 1; fiq_req = 1; irq_req = 1; pabt_req = 1; und_req = 1;
      step("R3 dabt wins"); gap();
      idle_inputs(); fiq_req = 1; irq_req = 1; pabt_req = 1; swi_req = 1; step("R3 fiq wins"); gap();
      idle_inputs(); irq_req = 1; pabt_req = 1; und_req = 1; step("R3 irq wins"); gap();
      idle_inputs(); pabt_req = 1; swi_req = 1; step("R3 pabt wins"); gap();
      idle_inputs(); und_req = 1; swi_req = 1; step("R3 und wins"); gap();
      idle_inputs(); status = 32'h0000_0040; fiq_req = 1; irq_req = 1; step("R3 R4 masked fiq yields"); gap();

      // R8: instruction boundary
      idle_inputs(); ex_idle = 0; dabt_req = 1; step("R8 no boundary"); gap();
      idle_inputs(); ex_idle = 0; rst_req = 1; step("R8 reset any time"); gap();
      idle_inputs(); ex_idle = 0; ex_done = 1; swi_req = 1; step("R8 done boundary"); gap();

      // R11: request held across the update cycle
      idle_inputs(); irq_req = 1; step("R11 first");
      step("R11 blocked");
      step("R11 again"); gap();
      idle_inputs(); pabt_req = 1; step("R11 entry");
      idle_inputs(); ex_done = 1; ret_req = 1; status = 32'h0000_00D2; step("R11 ret blocked"); gap();

      // R9 R10: returns
      idle_inputs(); ex_done = 1; ex_idle = 0; ret_req = 1; status = 32'h0000_00D2;
      saved = 32'h6000_0010; link = 32'h1234_5678; step("R9 return"); gap();
      idle_inputs(); ex_idle = 0; ret_req = 1; status = 32'h0000_00D2;
      saved = 32'h6000_0010; link = 32'h1234_5678; step("R9 no completion"); gap();
      idle_inputs(); ex_done = 1; ret_req = 1; status = 32'h0000_0010; link = 32'h0000_4444;
      step("R10 user"); gap();
      idle_inputs(); ex_done = 1; ret_req = 1; status = 32'h0000_001F; link = 32'h0000_4444;
      step("R10 system"); gap();
      idle_inputs(); ex_done = 1; ret_req = 1; irq_req = 1; status = 32'h0000_0011;
      saved = 32'h0000_0010; link = 32'h0000_8888; step("R9 entry precedes return"); gap();

      gap(); gap();
      wait (q.size() == 0);
      @(negedge clk);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule